// File: doc/BRIEF.md
# Two-Input Lossless Buffered Merger

This block joins two independent producer streams into one consumer stream. Each producer offers a valid flag and a data word every cycle, and either or both may be active together. Accepted words are kept in a small circular store and leave one per cycle, oldest first. The output always shows the oldest stored word, so it comes straight from flops with no combinational path from the inputs.

Words that arrive in the same cycle are ordered with port A ahead of port B. Across cycles, order follows arrival. There is no back-pressure in either direction. The producers have no ready signal, and the consumer must take the presented word in every cycle that `out_valid` is high, because the head is retired at each clock edge whether or not it is used. If a word arrives when the store has no room, it is dropped and a sticky error flag rises. Room is counted after the retirement of the head in that same edge.

Top module: `dual_merge_buffer`

## Requirements
- R1: A synchronous active-high `rst` empties the store and clears `overflow`. In the cycle after a reset edge, `out_valid` and `overflow` are both 0.
- R2: `out_valid` is 1 exactly when the store holds at least one word. `out_data` then equals the oldest stored word.
- R3: A word is never visible in its arrival cycle. A word taken into an empty store appears on `out_data` in the next cycle.
- R4: When both ports are valid in one cycle, the A word is stored ahead of the B word. From an empty store, A appears one cycle after arrival and B two cycles after.
- R5: When only one port is valid, only that port's word is stored. When neither is valid, nothing is stored, and an empty store stays empty.
- R6: At each clock edge with a non-empty store, exactly one word (the head) is retired. The output sequence follows arrival cycle, with A before B inside a cycle.
- R7: The store holds DEPTH words. Free room is measured after the same-edge retirement. A is admitted before B, and any word that finds no room is discarded.
- R8: `overflow` becomes 1 at the edge where a word is discarded. It stays 1 until reset, and it rises only at an edge where some input was valid.
- R9: While room remains, no word is lost or duplicated. Every admitted word appears on the output exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_valid | input | 1 | Port A carries a word this cycle |
| a_data | input | DATA_W | Port A word |
| b_valid | input | 1 | Port B carries a word this cycle |
| b_data | input | DATA_W | Port B word |
| out_valid | output | 1 | Merged stream has a word (store non-empty) |
| out_data | output | DATA_W | Oldest stored word |
| overflow | output | 1 | Sticky flag: some word was discarded for lack of room |

## Verification
The assertions take for granted that the consumer takes a word every cycle and that no ready signal exists. They also assume the store is at least two entries deep, so that a pair arriving at an empty store always fits. Their ordering checks start only from an empty store, which keeps them free of any model of occupancy. The stimulus keeps within these limits by using the default depth of four. It sweeps every sequence of four arrival patterns, each from a fresh reset and followed by a full drain, and gives every word a distinct value so that ordering faults and duplicates show up.

// File: rtl/merge_pkg.sv
package merge_pkg;

  // Outcome of the admission decision for one clock edge.
  typedef struct packed {
    logic keep_a;   // port A word is written
    logic keep_b;   // port B word is written
    logic lost;     // at least one valid word found no room
  } admit_t;

endpackage

// File: rtl/merge_admit.sv
// Decides which arriving words fit, given occupancy after the head leaves.
module merge_admit
  import merge_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] used_after_pop,
  input  logic             a_valid,
  input  logic             b_valid,
  output admit_t           adm
);

  localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);

  logic [CNT_W-1:0] free_slots;
  logic             room_one;
  logic             room_two;

  always_comb begin
    free_slots = CAP - used_after_pop;
    room_one   = (free_slots != '0);
    room_two   = (free_slots > CNT_W'(1));
  end

  always_comb begin
    adm.keep_a = a_valid && room_one;
    adm.keep_b = b_valid && (adm.keep_a ? room_two : room_one);
    adm.lost   = (a_valid && !adm.keep_a) || (b_valid && !adm.keep_b);
  end

endmodule

// File: rtl/merge_ring_ctrl.sv
// Read pointer and occupancy for the circular store; derives write slots.
module merge_ring_ctrl #(
  parameter int DEPTH = 4,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       push_n,
  output logic             pop,
  output logic [IDX_W-1:0] rd_idx,
  output logic [IDX_W-1:0] wr_idx0,
  output logic [IDX_W-1:0] wr_idx1,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] used_after_pop
);

  localparam int SUM_W = CNT_W + 1;
  localparam logic [SUM_W-1:0] SPAN = SUM_W'(DEPTH);

  function automatic logic [IDX_W-1:0] wrap_add(input logic [IDX_W-1:0] base,
                                                input logic [CNT_W-1:0] step);
    logic [SUM_W-1:0] raw;
    raw = SUM_W'(base) + SUM_W'(step);
    if (raw >= SPAN) raw = raw - SPAN;
    return raw[IDX_W-1:0];
  endfunction

  logic [IDX_W-1:0] rd_q;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    pop            = (cnt_q != '0);
    used_after_pop = cnt_q - CNT_W'(pop);
    rd_idx         = rd_q;
    count          = cnt_q;
    wr_idx0        = wrap_add(rd_q, cnt_q);
    wr_idx1        = wrap_add(wr_idx0, CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (pop) rd_q <= wrap_add(rd_q, CNT_W'(1));
      cnt_q <= used_after_pop + CNT_W'(push_n);
    end
  end

endmodule

// File: rtl/merge_ring_store.sv
// Storage cells with two write ports and one read port.
module merge_ring_store #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we0,
  input  logic [IDX_W-1:0]  idx0,
  input  logic [DATA_W-1:0] d0,
  input  logic              we1,
  input  logic [IDX_W-1:0]  idx1,
  input  logic [DATA_W-1:0] d1,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic [DATA_W-1:0] cell_q;
    always_ff @(posedge clk) begin
      if (we0 && idx0 == IDX_W'(g))      cell_q <= d0;
      else if (we1 && idx1 == IDX_W'(g)) cell_q <= d1;
    end
    assign cells[g] = cell_q;
  end

  always_comb begin
    q = cells[0];
    for (int i = 1; i < DEPTH; i++)
      if (rd_idx == IDX_W'(i)) q = cells[i];
  end

endmodule

// File: rtl/dual_merge_buffer.sv
module dual_merge_buffer
  import merge_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_valid,
  input  logic [DATA_W-1:0] a_data,
  input  logic              b_valid,
  input  logic [DATA_W-1:0] b_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              overflow
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             pop;
  logic [IDX_W-1:0] rd_idx, wr_idx0, wr_idx1;
  logic [CNT_W-1:0] count, used_after_pop;
  logic [1:0]       push_n;
  admit_t           adm;
  logic             we0, we1;
  logic [DATA_W-1:0] d0;
  logic             ovf_q;

  merge_ring_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rst(rst), .push_n(push_n), .pop(pop),
    .rd_idx(rd_idx), .wr_idx0(wr_idx0), .wr_idx1(wr_idx1),
    .count(count), .used_after_pop(used_after_pop)
  );

  merge_admit #(.DEPTH(DEPTH), .CNT_W(CNT_W)) admit_i (
    .used_after_pop(used_after_pop), .a_valid(a_valid), .b_valid(b_valid),
    .adm(adm)
  );

  // Slot 0 takes A when admitted, otherwise B; slot 1 takes B behind A.
  always_comb begin
    we0    = adm.keep_a || adm.keep_b;
    d0     = adm.keep_a ? a_data : b_data;
    we1    = adm.keep_a && adm.keep_b;
    push_n = {1'b0, adm.keep_a} + {1'b0, adm.keep_b};
  end

  merge_ring_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W)) store_i (
    .clk(clk),
    .we0(we0), .idx0(wr_idx0), .d0(d0),
    .we1(we1), .idx1(wr_idx1), .d1(b_data),
    .rd_idx(rd_idx), .q(out_data)
  );

  always_ff @(posedge clk) begin
    if (rst)          ovf_q <= 1'b0;
    else if (adm.lost) ovf_q <= 1'b1;
  end

  assign out_valid = pop;
  assign overflow  = ovf_q;

endmodule

// File: rtl/dual_merge_buffer_chk.sv
module dual_merge_buffer_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              a_valid,
  input logic [DATA_W-1:0] a_data,
  input logic              b_valid,
  input logic [DATA_W-1:0] b_data,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              overflow
);

  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && !overflow));

  p_idle_stays_empty_r5: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !a_valid && !b_valid) |=> !out_valid);

  p_lone_a_next_r3: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && a_valid && !b_valid) |=> (out_valid && out_data == $past(a_data)));

  p_lone_b_next_r5: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !a_valid && b_valid) |=> (out_valid && out_data == $past(b_data)));

  p_pair_a_first_r4: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && a_valid && b_valid) |=> (out_valid && out_data == $past(a_data)));

  p_pair_b_second_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && !out_valid && a_valid && b_valid)) |=>
      (out_valid && out_data == $past(b_data, 2)));

  p_overflow_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  p_overflow_cause_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $past(a_valid || b_valid));

endmodule

bind dual_merge_buffer dual_merge_buffer_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/dual_merge_buffer_tb_top.sv
module dual_merge_buffer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 8;
  localparam int DEPTH      = 4;
  localparam int SEQ_LEN    = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              a_valid = 1'b0, b_valid = 1'b0;
  logic [DATA_W-1:0] a_data = '0, b_data = '0;
  logic              out_valid;
  logic [DATA_W-1:0] out_data;
  logic              overflow;

  int checks = 0;
  int errors = 0;

  // reference queue
  int m_q [0:31];
  int m_n = 0;
  bit m_ovf = 0;
  int accepted = 0;
  int emitted  = 0;
  int tok = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_merge_buffer #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst),
    .a_valid(a_valid), .a_data(a_data),
    .b_valid(b_valid), .b_data(b_data),
    .out_valid(out_valid), .out_data(out_data), .overflow(overflow)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_push(input int v);
    if (m_n < DEPTH) begin
      m_q[m_n] = v;
      m_n++;
      accepted++;
    end else m_ovf = 1;
  endtask

  // Compare outputs with the model, then drive one cycle of inputs.
  task automatic step(input bit av, input bit bv);
    @(negedge clk);
    check(out_valid == (m_n != 0), "R2 out_valid", int'(out_valid), int'(m_n != 0));
    if (m_n != 0) begin
      check(out_data == DATA_W'(m_q[0]), "R6 R4 R9 order", int'(out_data), m_q[0]);
      if (out_valid) emitted++;
    end
    check(overflow == m_ovf, "R7 R8 overflow", int'(overflow), int'(m_ovf));
    a_valid = av; b_valid = bv;
    a_data  = DATA_W'(tok); b_data = DATA_W'(tok + 1);
    // model of the coming edge: retire head, then A, then B
    if (m_n != 0) begin
      for (int i = 0; i < 31; i++) m_q[i] = m_q[i+1];
      m_n--;
    end
    if (av) model_push(tok % 256);
    if (bv) model_push((tok + 1) % 256);
    tok = (tok + 2) % 250;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; a_valid = 0; b_valid = 0;
    @(negedge clk);
    rst = 0;
    m_n = 0; m_ovf = 0;
    check(!out_valid, "R1 out_valid after reset", int'(out_valid), 0);
    check(!overflow, "R1 overflow after reset", int'(overflow), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();

    // R3: lone A not visible in arrival cycle, visible next cycle
    @(negedge clk);
    a_valid = 1; b_valid = 0; a_data = 8'hA5;
    #1 check(!out_valid, "R3 not visible same cycle", int'(out_valid), 0);
    @(negedge clk);
    a_valid = 0;
    check(out_valid && out_data == 8'hA5, "R3 visible next cycle", int'(out_data), 'hA5);
    @(negedge clk);
    check(!out_valid, "R5 empty after lone word", int'(out_valid), 0);

    // R5: lone B only
    b_valid = 1; b_data = 8'h3C;
    @(negedge clk);
    b_valid = 0;
    check(out_valid && out_data == 8'h3C, "R5 lone B stored", int'(out_data), 'h3C);
    @(negedge clk);
    check(!out_valid, "R5 idle keeps empty", int'(out_valid), 0);

    // Near-exhaustive sweep: every sequence of SEQ_LEN patterns
    for (int s = 0; s < (1 << (2 * SEQ_LEN)); s++) begin
      do_reset();
      accepted = 0; emitted = 0;
      for (int c = 0; c < SEQ_LEN; c++) begin
        step(bit'((s >> (2*c)) & 1), bit'((s >> (2*c + 1)) & 1));
      end
      for (int d = 0; d < DEPTH + 2; d++) step(1'b0, 1'b0);
      check(emitted == accepted, "R9 every admitted word emitted once", emitted, accepted);
    end

    // R1: reset while full and overflowed
    do_reset();
    for (int c = 0; c < 4; c++) step(1'b1, 1'b1);
    step(1'b0, 1'b0);
    do_reset();
    check(!out_valid && !overflow, "R1 reset from full", int'(out_valid), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule